// File: doc/BRIEF.md
# Drive Amplitude Calibration Sequencer

This block sets the drive gain for one test site and then runs the measurement bursts for that site. A start command loads a nominal gain code and issues one calibration burst. This burst has the same shape as the first burst of a measurement. When the burst completes, the measured fundamental-current amplitude comes back. The gain is then multiplied by the ratio of the target amplitude to the measured amplitude. This calibration round runs twice in total. The gain that results drives the digital-to-analog converter for the rest of the site.

Once the gain is settled, the block runs a measurement of four bursts with phase indices 0, 1, 2 and 3. It repeats that measurement a programmed number of times so that the results can be averaged. It then pulses a completion flag. Calibration runs once per site and is not repeated between measurement repeats. If the amplitude read back is too small to be a real current, the block reports an open circuit and stops the site.

Burst requests leave the block on a valid/ready handshake. `burst_req_valid` is asserted with `burst_cal` and `burst_phase`, and these three stay constant until the cycle in which `burst_req_ready` is high. The transfer happens in that cycle. A low `burst_req_ready` stalls the sequencer for as long as it stays low. Only one burst is in flight at a time. The completion of a burst is a single-cycle `burst_done` strobe, and `meas_amp` is valid in that same cycle.

Top module: `drive_cal_seq`

## Requirements
- R1: A `site_start` pulse seen while `busy` is low loads `dac_gain` with `nominal_gain` on the next clock. In that same cycle the first request appears: `burst_req_valid`=1, `burst_cal`=1 and `burst_phase`=0.
- R2: Exactly two calibration bursts are issued. On the `burst_done` of each one, `dac_gain` becomes floor(`dac_gain` × `target_amp` / `meas_amp`). The result saturates at the all-ones code 2^GAIN_W−1.
- R3: After the second calibration, measurement requests carry `burst_cal`=0 and `burst_phase` 0, 1, 2, 3 in that order. `dac_gain` does not change during the measurement phase.
- R4: The four-burst measurement runs N times in a row without recalibration. N is `repeat_count`, latched at the start. A value of 0 is treated as 1, and values from 1 to 255 are used as given.
- R5: `site_done` is a one-cycle pulse in the clock after the `burst_done` of the last measurement burst. `busy` is low in that same cycle.
- R6: A calibration `burst_done` with `meas_amp` < MIN_AMP (zero included) ends the site. `busy` drops, `dac_gain` keeps its value from before that burst, and `site_done` does not pulse. `open_err` goes high and stays high until the next accepted `site_start`.
- R7: A request that is not accepted holds `burst_req_valid`, `burst_cal` and `burst_phase` steady. No new request is raised until the `burst_done` of the one already in flight.
- R8: `site_start` while `busy` is high is ignored. `burst_done` is ignored when no burst is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| site_start | input | 1 | Start-of-site command pulse |
| nominal_gain | input | GAIN_W | Starting gain code for calibration |
| target_amp | input | AMP_W | Desired fundamental-current amplitude |
| repeat_count | input | REP_W | Number of measurement repeats (0 treated as 1) |
| burst_req_valid | output | 1 | Burst request valid |
| burst_req_ready | input | 1 | Burst request accepted |
| burst_cal | output | 1 | Request is a calibration burst |
| burst_phase | output | 2 | Burst phase index within a measurement |
| burst_done | input | 1 | Burst finished strobe |
| meas_amp | input | AMP_W | Measured fundamental amplitude, valid with burst_done |
| dac_gain | output | GAIN_W | Gain code to the drive DAC |
| busy | output | 1 | Site sequence in progress |
| site_done | output | 1 | One-cycle pulse when all repeats are finished |
| open_err | output | 1 | Open-circuit abort flag, held until next start |

## Verification
The bench goes after the saturation corner, where a weak load makes the ratio exceed full scale; a design that wraps instead of clamping would output a small gain. It aborts both on the first calibration burst and on the second, so a design that scales before it tests the threshold shows a changed gain. A zero repeat count and a 255 repeat count check the ends of the repeat range: an off-by-one would produce one measurement too many or too few, or none at all. Back-pressure on requests, stray completion strobes and start commands arriving mid-site check that nothing moves without a handshake.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_REQ,
    ST_CAL_WAIT,
    ST_MEAS_REQ,
    ST_MEAS_WAIT
  } dcs_state_e;

  localparam int BURSTS_PER_MEAS = 4;
  localparam int PHASE_W = $clog2(BURSTS_PER_MEAS);
endpackage

// File: rtl/dcs_gain_scaler.sv
// Ratio scaling of the gain code: gain * target / measured, clamped to full scale.
module dcs_gain_scaler #(
  parameter int GAIN_W = 12,
  parameter int AMP_W  = 12
) (
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [AMP_W-1:0]  target_i,
  input  logic [AMP_W-1:0]  meas_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int PROD_W = GAIN_W + AMP_W;
  localparam logic [PROD_W-1:0] FULL = {{AMP_W{1'b0}}, {GAIN_W{1'b1}}};

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] den;
  logic [PROD_W-1:0] quo;

  assign prod = PROD_W'(gain_i) * PROD_W'(target_i);
  assign den  = PROD_W'(meas_i);

  always_comb begin
    if (den == '0) quo = FULL;
    else           quo = prod / den;
  end

  assign gain_o = (quo > FULL) ? {GAIN_W{1'b1}} : quo[GAIN_W-1:0];
endmodule

// File: rtl/dcs_rep_tracker.sv
// Tracks the burst phase within a measurement and the measurement repeats left.
module dcs_rep_tracker #(
  parameter int REP_W   = 8,
  parameter int BURSTS  = 4,
  parameter int PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [REP_W-1:0]   count_i,
  input  logic               step_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               last_o
);
  localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(BURSTS - 1);

  logic [PHASE_W-1:0] phase_q;
  logic [REP_W-1:0]   left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      left_q  <= '0;
    end else if (load_i) begin
      phase_q <= '0;
      left_q  <= (count_i == '0) ? REP_W'(1) : count_i;
    end else if (step_i) begin
      if (phase_q == PH_LAST) begin
        phase_q <= '0;
        left_q  <= left_q - REP_W'(1);
      end else begin
        phase_q <= phase_q + PHASE_W'(1);
      end
    end
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == PH_LAST) && (left_q == REP_W'(1));
endmodule

// File: rtl/drive_cal_seq.sv
module drive_cal_seq #(
  parameter int GAIN_W     = 12,
  parameter int AMP_W      = 12,
  parameter int REP_W      = 8,
  parameter int MIN_AMP    = 16,
  parameter int CAL_ROUNDS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         site_start,
  input  logic [GAIN_W-1:0]            nominal_gain,
  input  logic [AMP_W-1:0]             target_amp,
  input  logic [REP_W-1:0]             repeat_count,
  output logic                         burst_req_valid,
  input  logic                         burst_req_ready,
  output logic                         burst_cal,
  output logic [dcs_pkg::PHASE_W-1:0]  burst_phase,
  input  logic                         burst_done,
  input  logic [AMP_W-1:0]             meas_amp,
  output logic [GAIN_W-1:0]            dac_gain,
  output logic                         busy,
  output logic                         site_done,
  output logic                         open_err
);
  import dcs_pkg::*;

  localparam int CAL_W = $clog2(CAL_ROUNDS) + 1;
  localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_ROUNDS - 1);
  localparam logic [AMP_W-1:0] AMP_FLOOR = AMP_W'(MIN_AMP);

  dcs_state_e          st_q;
  logic [GAIN_W-1:0]   gain_q;
  logic [GAIN_W-1:0]   gain_scaled;
  logic [CAL_W-1:0]    cal_q;
  logic                done_q;
  logic                err_q;
  logic [PHASE_W-1:0]  phase;
  logic                last_burst;
  logic                trk_load;
  logic                trk_step;

  assign trk_load = (st_q == ST_IDLE) && site_start;
  assign trk_step = (st_q == ST_MEAS_WAIT) && burst_done;

  dcs_gain_scaler #(.GAIN_W(GAIN_W), .AMP_W(AMP_W)) u_scaler (
    .gain_i   (gain_q),
    .target_i (target_amp),
    .meas_i   (meas_amp),
    .gain_o   (gain_scaled)
  );

  dcs_rep_tracker #(.REP_W(REP_W), .BURSTS(BURSTS_PER_MEAS), .PHASE_W(PHASE_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (trk_load),
    .count_i (repeat_count),
    .step_i  (trk_step),
    .phase_o (phase),
    .last_o  (last_burst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gain_q <= '0;
      cal_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (site_start) begin
            gain_q <= nominal_gain;
            cal_q  <= '0;
            err_q  <= 1'b0;
            st_q   <= ST_CAL_REQ;
          end
        end
        ST_CAL_REQ: begin
          if (burst_req_ready) st_q <= ST_CAL_WAIT;
        end
        ST_CAL_WAIT: begin
          if (burst_done) begin
            if (meas_amp < AMP_FLOOR) begin
              err_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              gain_q <= gain_scaled;
              if (cal_q == CAL_LAST) begin
                st_q <= ST_MEAS_REQ;
              end else begin
                cal_q <= cal_q + CAL_W'(1);
                st_q  <= ST_CAL_REQ;
              end
            end
          end
        end
        ST_MEAS_REQ: begin
          if (burst_req_ready) st_q <= ST_MEAS_WAIT;
        end
        ST_MEAS_WAIT: begin
          if (burst_done) begin
            if (last_burst) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_MEAS_REQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign burst_req_valid = (st_q == ST_CAL_REQ) || (st_q == ST_MEAS_REQ);
  assign burst_cal       = (st_q == ST_CAL_REQ);
  assign burst_phase     = (st_q == ST_MEAS_REQ) ? phase : '0;
  assign dac_gain        = gain_q;
  assign busy            = (st_q != ST_IDLE);
  assign site_done       = done_q;
  assign open_err        = err_q;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int GAIN_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              site_start,
  input logic [GAIN_W-1:0] nominal_gain,
  input logic              burst_req_valid,
  input logic              burst_req_ready,
  input logic              burst_cal,
  input logic [1:0]        burst_phase,
  input logic [GAIN_W-1:0] dac_gain,
  input logic              busy,
  input logic              site_done,
  input logic              open_err
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req_valid && !burst_req_ready) |=>
      (burst_req_valid && $stable(burst_cal) && $stable(burst_phase)));

  // R3
  meas_gain_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req_valid && !burst_cal) |=> $stable(dac_gain));

  // R1
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && site_start) |=>
      (dac_gain == $past(nominal_gain) && burst_req_valid && burst_cal && burst_phase == 2'd0));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    site_done |=> !site_done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    site_done |-> !busy);

  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_err |-> (!busy && !site_done));
endmodule

bind drive_cal_seq dcs_checker #(.GAIN_W(GAIN_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .site_start      (site_start),
  .nominal_gain    (nominal_gain),
  .burst_req_valid (burst_req_valid),
  .burst_req_ready (burst_req_ready),
  .burst_cal       (burst_cal),
  .burst_phase     (burst_phase),
  .dac_gain        (dac_gain),
  .busy            (busy),
  .site_done       (site_done),
  .open_err        (open_err)
);

// File: tb/drive_cal_seq_tb.sv
`timescale 1ns/1ps
module drive_cal_seq_tb;
  localparam int GW = 12, AW = 12, RW = 8, MINA = 16;
  localparam int GMAX = (1 << GW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic site_start = 1'b0;
  logic [GW-1:0] nominal_gain = '0;
  logic [AW-1:0] target_amp = '0;
  logic [RW-1:0] repeat_count = '0;
  logic burst_req_valid, burst_req_ready = 1'b0, burst_cal, burst_done = 1'b0;
  logic [1:0] burst_phase;
  logic [AW-1:0] meas_amp = '0;
  logic [GW-1:0] dac_gain;
  logic busy, site_done, open_err;

  drive_cal_seq #(.GAIN_W(GW), .AMP_W(AW), .REP_W(RW), .MIN_AMP(MINA)) u_dut (
    .clk(clk), .rst_n(rst_n), .site_start(site_start), .nominal_gain(nominal_gain),
    .target_amp(target_amp), .repeat_count(repeat_count),
    .burst_req_valid(burst_req_valid), .burst_req_ready(burst_req_ready),
    .burst_cal(burst_cal), .burst_phase(burst_phase), .burst_done(burst_done),
    .meas_amp(meas_amp), .dac_gain(dac_gain), .busy(busy), .site_done(site_done),
    .open_err(open_err));

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 cal request, 2 cal wait, 3 meas request, 4 meas wait
  int m_st = 0, m_gain = 0, m_cal = 0, m_b = 0, m_left = 0, m_done = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_gain = 0; m_cal = 0; m_b = 0; m_left = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (site_start) begin
             m_gain = nominal_gain; m_cal = 0; m_err = 0; m_b = 0;
             m_left = (repeat_count == 0) ? 1 : repeat_count;
             m_st = 1;
           end
        1: if (burst_req_ready) m_st = 2;
        2: if (burst_done) begin
             if (meas_amp < MINA) begin
               m_err = 1; m_st = 0;
             end else begin
               int q;
               q = (m_gain * target_amp) / meas_amp;
               m_gain = (q > GMAX) ? GMAX : q;
               if (m_cal == 1) m_st = 3;
               else begin m_cal = 1; m_st = 1; end
             end
           end
        3: if (burst_req_ready) m_st = 4;
        4: if (burst_done) begin
             if (m_b == 3) begin
               m_b = 0; m_left--;
               if (m_left == 0) begin m_done = 1; m_st = 0; end
               else m_st = 3;
             end else begin
               m_b++; m_st = 3;
             end
           end
        default: m_st = 0;
      endcase
    end
  end

  // Environment: burst engine with back-pressure, fixed latency and a load model
  int pend = 0, rcnt = 0, load_num = 256, n_cal = 0, n_meas = 0, done_seen = 0;
  bit stray = 0;

  function automatic int amp_of(input int g);
    int a;
    a = (g * load_num) >> 8;
    return (a > GMAX) ? GMAX : a;
  endfunction

  always @(negedge clk) begin
    burst_done = 1'b0;
    burst_req_ready = 1'b0;
    if (stray) begin
      burst_done = 1'b1; meas_amp = AW'(5);
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin burst_done = 1'b1; meas_amp = AW'(amp_of(int'(dac_gain))); end
    end else if (burst_req_valid) begin
      rcnt++;
      if (rcnt % 3 != 0) begin
        burst_req_ready = 1'b1; pend = 3;
        if (burst_cal) n_cal++; else n_meas++;
      end
    end
  end

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(burst_req_valid === (m_st == 1 || m_st == 3), "R7 burst_req_valid", burst_req_valid, (m_st == 1 || m_st == 3));
      chk(burst_cal === (m_st == 1), "R1 burst_cal", burst_cal, (m_st == 1));
      chk(burst_phase === ((m_st == 3) ? 2'(m_b) : 2'd0), "R3 burst_phase", burst_phase, (m_st == 3) ? m_b : 0);
      chk(dac_gain === GW'(m_gain), "R2 dac_gain", dac_gain, m_gain);
      chk(busy === (m_st != 0), "R8 busy", busy, (m_st != 0));
      chk(site_done === m_done[0], "R5 site_done", site_done, m_done);
      chk(open_err === m_err[0], "R6 open_err", open_err, m_err);
      if (site_done) done_seen++;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_site(input int nom, input int tgt, input int rc, input int ld,
                          input int exp_cal, input int exp_meas, input bit exp_err,
                          input int exp_gain, input bit poke);
    n_cal = 0; n_meas = 0; done_seen = 0; load_num = ld;
    @(negedge clk);
    nominal_gain = GW'(nom); target_amp = AW'(tgt); repeat_count = RW'(rc);
    site_start = 1'b1;
    @(negedge clk);
    site_start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      nominal_gain = GW'(77); repeat_count = RW'(9); site_start = 1'b1;   // R8 start while busy
      @(negedge clk);
      site_start = 1'b0;
    end
    while (m_st != 0) @(negedge clk);
    @(negedge clk);
    chk(n_cal == exp_cal, "R2 calibration burst count", n_cal, exp_cal);
    chk(n_meas == exp_meas, "R4 measurement burst count", n_meas, exp_meas);
    chk(open_err == exp_err, "R6 open flag at end", open_err, exp_err);
    chk(done_seen == (exp_err ? 0 : 1), "R5 done pulses", done_seen, exp_err ? 0 : 1);
    chk(int'(dac_gain) == exp_gain, "R2 final gain", dac_gain, exp_gain);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_gain == 0, "R1 reset gain", dac_gain, 0);
    chk(busy == 0 && burst_req_valid == 0, "R1 reset idle", {busy, burst_req_valid}, 0);

    // R2 nominal 1000 at unity load -> 800 -> 800, three repeats (R4)
    run_site(1000, 800, 3, 256, 2, 12, 0, 800, 0);
    // R2 saturation: load reads a quarter of gain
    run_site(2000, 2000, 2, 64, 2, 8, 0, GMAX, 0);
    // R6 open circuit on first calibration burst: gain keeps nominal
    run_site(500, 800, 4, 0, 1, 0, 1, 500, 0);
    // R6 low amplitude on second burst: gain stays at first-scaled value 10
    run_site(4095, 10, 1, 256, 2, 0, 1, 10, 0);
    // R4 repeat count 0 treated as 1; R8 start during busy ignored
    run_site(600, 300, 0, 256, 2, 4, 0, 300, 1);

    // R8 stray done while idle has no effect
    stray = 1; @(negedge clk); stray = 0;
    repeat (2) @(negedge clk);
    chk(int'(dac_gain) == 300, "R8 gain after stray done", dac_gain, 300);
    chk(busy == 0, "R8 idle after stray done", busy, 0);

    // R4 maximum repeat count
    run_site(100, 300, 255, 256, 2, 1020, 0, 300, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule